// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a microcontroller-class system. A free-running prescaler counter runs from the internal clock. Each time the prescaler wraps, the watchdog counter advances by one. When the watchdog counter overflows, the block raises a timeout toward the reset controller. Software keeps the system alive by writing to the service address before that overflow. A service write clears the watchdog counter. It also clears the upper field of the shared prescaler, so the time to the next advance is almost a full prescaler period.

The watchdog can be switched off only by a high-voltage indication on either of two pins. That indication acts through combinational gating, so no stored bit can turn the watchdog off. The prescaler value is brought out so that other logic can share it. Software should service the watchdog right after reset to get the longest margin before the first timeout.

Top module: `wdg_top`

## Requirements
- R1: While `rstN` is low, `prescOut` reads 0 and `wdTimeout` is 0, and asserting `rstN` clears both counters at once. The first rising edge after release leaves `prescOut` at 1.
- R2: In every cycle without a service write, the prescaler advances by one, wrapping from all ones to zero.
- R3: The watchdog counter advances in each cycle where the prescaler holds all ones. With no service write and no disable, the first timeout pulse appears after the 2^(PRE_W+WD_W)-th rising edge following reset release.
- R4: A write with `busWrEn`=1 and `busAddr`=SVC_ADDR (default 16'hFFFF) services the watchdog, whatever the `busWrData` value. It clears the watchdog counter and zeroes prescaler bits [PRE_W-1:KEEP_W]. The low KEEP_W bits advance by one and wrap within their own field.
- R5: A write to any other address has no effect: the prescaler keeps advancing and the timeout arrives as if the write had not happened.
- R6: A timeout is exactly one cycle high. After it, no further pulse appears until reset, even after more overflow periods.
- R7: If a service write lands in the same cycle as a watchdog overflow, no timeout pulse is issued and both counters take their serviced values.
- R8: While `hvDetRst` or `hvDetIrq` is high, the watchdog counter does not advance and `wdTimeout` is forced to 0 combinationally, even in a cycle where a pulse is already registered. Once both pins are low, counting resumes from the held value.
- R9: After a service write that leaves the low field at value p, the timeout pulse follows the 2^(PRE_W+WD_W) − p-th edge after the service edge, unless another service write comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Internal reset, active low, asynchronous |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus write address |
| busWrData | input | 8 | Bus write data, ignored |
| hvDetRst | input | 1 | High-voltage detect on the reset pin |
| hvDetIrq | input | 1 | High-voltage detect on the interrupt pin |
| prescOut | output | PRE_W | Shared prescaler value |
| wdTimeout | output | 1 | One-cycle timeout pulse to the reset controller |

## Verification
A wrong prescaler state shows on `prescOut` in the very next cycle. It also shifts the timeout edge by a whole number of cycles, so the bench measures the timeout position to the exact edge instead of checking a window. A watchdog counter that is cleared badly or advanced badly stays hidden until the next timeout, up to 2^(PRE_W+WD_W) cycles later. Each scenario therefore runs on to its timeout and compares the edge count. A stuck pulse or an unwanted re-arm shows as a second high cycle within four further periods.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Strobes issued by the control to the counters
  typedef struct packed {
    logic svcClr;     // service: clear watchdog and prescaler upper field
    logic wdAdvance;  // advance the watchdog counter this cycle
  } ctlStr_t;

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int PRE_W  = 13,
  parameter int KEEP_W = 5,
  parameter int WD_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStr_t          str,
  output logic [PRE_W-1:0] presc,
  output logic             prescWrap,
  output logic             wdAtMax
);

  localparam int CLR_W = PRE_W - KEEP_W;

  logic [PRE_W-1:0] prescSvc;
  logic [WD_W-1:0]  wdCnt;

  // Serviced prescaler value: upper field zero, low field steps on
  generate
    if (KEEP_W > 0) begin : g_keepLow
      logic [KEEP_W-1:0] lowNext;
      assign lowNext  = presc[KEEP_W-1:0] + 1'b1;
      assign prescSvc = {{CLR_W{1'b0}}, lowNext};
    end else begin : g_clearAll
      assign prescSvc = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           presc <= '0;
    else if (str.svcClr) presc <= prescSvc;
    else                 presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wdCnt <= '0;
    else if (str.svcClr)    wdCnt <= '0;
    else if (str.wdAdvance) wdCnt <= wdCnt + 1'b1;
  end

  assign prescWrap = &presc;
  assign wdAtMax   = &wdCnt;

  // Assertions
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  p_presc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(str.svcClr)) |-> (presc == $past(presc) + 1'b1));

  p_presc_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(str.svcClr)) |-> (presc[PRE_W-1:KEEP_W] == '0));

  p_wd_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(str.svcClr)) |-> (wdCnt == '0));

  p_wd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(str.svcClr) && !$past(str.wdAdvance)) |-> $stable(wdCnt));

endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              hvDetRst,
  input  logic              hvDetIrq,
  input  logic              prescWrap,
  input  logic              wdAtMax,
  output ctlStr_t           str,
  output logic              wdTimeout
);

  logic svcHit;
  logic hvDet;
  logic overflow;
  logic toPulse;
  logic fired;
  logic dataIgnored_unused;

  assign dataIgnored_unused = ^busWrData;

  assign svcHit = busWrEn && (busAddr == SVC_ADDR);
  assign hvDet  = hvDetRst | hvDetIrq;

  always_comb begin
    str.svcClr    = svcHit;
    str.wdAdvance = prescWrap & ~hvDet & ~svcHit;
  end

  assign overflow = str.wdAdvance & wdAtMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toPulse <= 1'b0;
      fired   <= 1'b0;
    end else begin
      toPulse <= overflow & ~fired;
      fired   <= fired | overflow;
    end
  end

  // Disable acts only through gating, never through a stored bit
  assign wdTimeout = toPulse & ~hvDet;

  // Assertions
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    toPulse |=> !toPulse);

  p_no_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    fired |=> !toPulse);

  p_svc_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    svcHit |=> !toPulse);

  p_no_adv_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    hvDet |=> !toPulse);

endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int                PRE_W    = 13,
  parameter int                KEEP_W   = 5,
  parameter int                WD_W     = 6,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              hvDetRst,
  input  logic              hvDetIrq,
  output logic [PRE_W-1:0]  prescOut,
  output logic              wdTimeout
);

  ctlStr_t str;
  logic    prescWrap;
  logic    wdAtMax;

  wdg_control #(
    .ADDR_W   (ADDR_W),
    .SVC_ADDR (SVC_ADDR)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .hvDetRst  (hvDetRst),
    .hvDetIrq  (hvDetIrq),
    .prescWrap (prescWrap),
    .wdAtMax   (wdAtMax),
    .str       (str),
    .wdTimeout (wdTimeout)
  );

  wdg_datapath #(
    .PRE_W  (PRE_W),
    .KEEP_W (KEEP_W),
    .WD_W   (WD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .presc     (prescOut),
    .prescWrap (prescWrap),
    .wdAtMax   (wdAtMax)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |-> (prescOut == '0 && !wdTimeout));

endmodule

// File: tb/wdg_top_tb.sv
module wdg_top_tb;

  localparam int PRE_W  = 8;
  localparam int KEEP_W = 3;
  localparam int WD_W   = 3;
  localparam int PERIOD = 1 << (PRE_W + WD_W);  // 2048 edges

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWrEn = 1'b0;
  logic [15:0]      busAddr = '0;
  logic [7:0]       busWrData = '0;
  logic             hvDetRst = 1'b0;
  logic             hvDetIrq = 1'b0;
  logic [PRE_W-1:0] prescOut;
  logic             wdTimeout;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;  // 100 MHz

  wdg_top #(
    .PRE_W (PRE_W), .KEEP_W (KEEP_W), .WD_W (WD_W), .ADDR_W (16), .SVC_ADDR (16'hFFFF)
  ) u_dut (
    .clk (clk), .rstN (rstN), .busWrEn (busWrEn), .busAddr (busAddr),
    .busWrData (busWrData), .hvDetRst (hvDetRst), .hvDetIrq (hvDetIrq),
    .prescOut (prescOut), .wdTimeout (wdTimeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge where rstN was released (no edge since)
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(prescOut == 0, "R1 prescaler cleared by reset", prescOut, 0);
    repeat (3) @(negedge clk);
    check(prescOut == 0 && !wdTimeout, "R1 quiet during reset", {wdTimeout, prescOut}, 0);
    rstN = 1'b1;
  endtask

  // Counts edges until wdTimeout is seen high at a negedge
  task automatic waitTimeout(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (wdTimeout) break;
    end
  endtask

  task automatic svcWrite(input logic [15:0] addr, input logic [7:0] data);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic t_reset_and_count();
    doReset();
    @(negedge clk);
    check(prescOut == 1, "R1 first edge after release", prescOut, 1);
    repeat (300) @(negedge clk);
    check(prescOut == 301 % 256, "R2 prescaler wraps", prescOut, 301 % 256);
  endtask

  task automatic t_first_timeout();
    int n;
    doReset();
    waitTimeout(3 * PERIOD, n);
    check(n == PERIOD, "R3 first timeout edge", n, PERIOD);
  endtask

  task automatic t_pulse_once();
    int n;
    int extra;
    doReset();
    waitTimeout(3 * PERIOD, n);
    @(negedge clk);
    check(!wdTimeout, "R6 pulse is one cycle", wdTimeout, 0);
    extra = 0;
    repeat (4 * PERIOD) begin
      @(negedge clk);
      if (wdTimeout) extra++;
    end
    check(extra == 0, "R6 no re-arm before reset", extra, 0);
  endtask

  task automatic t_service_mid();
    int n;
    doReset();
    repeat (173) @(negedge clk);
    svcWrite(16'hFFFF, 8'h00);
    check(prescOut == 6, "R4 upper field cleared low steps", prescOut, 6);
    waitTimeout(3 * PERIOD, n);
    check(n == PERIOD - 6, "R9 timeout after service", n, PERIOD - 6);
  endtask

  task automatic t_service_lowwrap();
    int n;
    doReset();
    repeat (7) @(negedge clk);
    svcWrite(16'hFFFF, 8'hFF);
    check(prescOut == 0, "R4 low field wraps, data ignored", prescOut, 0);
    waitTimeout(3 * PERIOD, n);
    check(n == PERIOD, "R9 timeout after service p=0", n, PERIOD);
  endtask

  task automatic t_wrong_addr();
    int n;
    doReset();
    repeat (100) @(negedge clk);
    svcWrite(16'hFFFE, 8'h5A);
    check(prescOut == 101, "R5 other address ignored", prescOut, 101);
    waitTimeout(3 * PERIOD, n);
    check(n == PERIOD - 101, "R5 timeout unchanged", n, PERIOD - 101);
  endtask

  task automatic t_collision();
    int n;
    doReset();
    repeat (PERIOD - 1) @(negedge clk);
    check(prescOut == 255 && !wdTimeout, "R7 setup at overflow cycle", prescOut, 255);
    svcWrite(16'hFFFF, 8'h33);
    check(!wdTimeout, "R7 service beats overflow", wdTimeout, 0);
    check(prescOut == 0, "R7 prescaler serviced", prescOut, 0);
    waitTimeout(3 * PERIOD, n);
    check(n == PERIOD, "R7 counter restarted", n, PERIOD);
  endtask

  task automatic t_disable(input bit useIrq);
    int n;
    int seen;
    if (useIrq) hvDetIrq = 1'b1; else hvDetRst = 1'b1;
    doReset();
    seen = 0;
    repeat (5000) begin
      @(negedge clk);
      if (wdTimeout) seen++;
    end
    check(seen == 0, "R8 no timeout while disabled", seen, 0);
    hvDetIrq = 1'b0; hvDetRst = 1'b0;
    waitTimeout(3 * PERIOD, n);
    check(n == 1912, "R8 counting resumes from held value", n, 1912);
  endtask

  task automatic t_gate_pulse();
    doReset();
    repeat (PERIOD) @(negedge clk);
    check(wdTimeout, "R3 pulse present", wdTimeout, 1);
    hvDetIrq = 1'b1;
    #1;
    check(!wdTimeout, "R8 combinational gating", wdTimeout, 0);
    hvDetIrq = 1'b0;
    #1;
    check(wdTimeout, "R8 gating released", wdTimeout, 1);
  endtask

  task automatic t_async_reset();
    doReset();
    repeat (50) @(negedge clk);
    #2;
    rstN = 1'b0;
    #1;
    check(prescOut == 0, "R1 asynchronous clear", prescOut, 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_and_count();
    t_first_timeout();
    t_pulse_once();
    t_service_mid();
    t_service_lowwrap();
    t_wrong_addr();
    t_collision();
    t_disable(1'b0);
    t_disable(1'b1);
    t_gate_pulse();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule